// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum and a carry-out. It is purely combinational. It has no register, no clock and no reset, so a result follows its inputs within the same cycle. It is meant to sit inside a datapath where the ripple of a plain carry chain would set the critical path.

The operand bits are grouped into four slices of four bits. Each slice forms the propagate and generate term of each bit. It resolves its own internal carries with flattened lookahead terms, and it reports one group propagate and one group generate. A second lookahead unit takes these four pairs and the carry-in, and it returns the carry into each slice and the final carry-out.

Both lookahead levels use one shared carry network. In that network every carry is a flattened sum of products, so no carry is formed from another carry. The widths are parameters, with a 16-bit total and a 4-bit slice as defaults.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, for any operands and either carry-in.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: The carry entering the slice that starts at bit 4k (k = 1, 2, 3) equals bit 4k of the sum of the operand bits below 4k plus `cin_i`. A carry therefore crosses every slice boundary correctly, for example 0x000F + 0x0001 gives 0x0010.
- R4: When a slice generates as a group, its bits produce a carry out of the slice whatever its carry-in. An example is 0x00F0 + 0x0010, which gives 0x0100.
- R5: When a slice propagates as a group, its two 4-bit operand fields are bitwise complements. Such a slice passes its carry-in straight through, so 0xFFFF + 0x0000 with carry-in 1 gives sum 0x0000 and carry-out 1. A slice never propagates and generates as a group at the same time.
- R6: 0x0000 + 0x0000 with carry-in 0 gives sum 0x0000 and carry-out 0.
- R7: 0xFFFF + 0xFFFF with carry-in 1 gives sum 0xFFFF and carry-out 1. 0xFFFF + 0x0001 with carry-in 0 gives sum 0x0000 and carry-out 1.
- R8: With alternating bit patterns, 0x5555 + 0xAAAA gives 0xFFFF and carry-out 0 with carry-in 0. The same operands give 0x0000 and carry-out 1 with carry-in 1.
- R9: The outputs depend only on the present inputs. No clock edge lies between a change of the operands and a valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Every result of this block, including the sum, the carry-out and the internal slice carries, is due in the same cycle that its operands are applied, so the latency is zero. The bench drives the operands just after a rising edge and reads the outputs at the following falling edge, half a period later. By then the combinational network has settled, and no edge ordering can affect the comparison. The internal checks of the group terms and the slice carries are evaluated each time their inputs change, against sums formed independently of the lookahead terms.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned DEF_WIDTH   = 16;
  localparam int unsigned DEF_SLICE_W = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } bit_pg_t;

  // Per-bit propagate and generate terms.
  function automatic bit_pg_t bit_pg(input logic x, input logic y);
    bit_pg_t r;
    r.prop = x ^ y;
    r.gen  = x & y;
    return r;
  endfunction

  // Sum bit from propagate and incoming carry.
  function automatic logic sum_bit(input logic prop, input logic carry);
    return prop ^ carry;
  endfunction

endpackage

// File: rtl/cla_carry_net.sv
// Flattened lookahead network: each carry is an OR of product terms
// built straight from p, g and cin, never from another carry.
module cla_carry_net #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N-1:0] c_in_pos,
  output logic         grp_p,
  output logic         grp_g
);

  always_comb begin
    logic acc;
    logic prod;
    c_in_pos    = '0;
    c_in_pos[0] = cin;
    for (int i = 1; i < N; i++) begin
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        prod = g[j];
        for (int k = j + 1; k < i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k < i; k++) prod = prod & p[k];
      c_in_pos[i] = acc | prod;
    end
  end

  always_comb begin
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      prod = g[j];
      for (int k = j + 1; k < N; k++) prod = prod & p[k];
      acc = acc | prod;
    end
    grp_g = acc;
    grp_p = &p;
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
#(
  parameter int unsigned SW = DEF_SLICE_W
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          cin,
  output logic [SW-1:0] sum,
  output logic          grp_p,
  output logic          grp_g
);

  logic [SW-1:0] p_bits;
  logic [SW-1:0] g_bits;
  logic [SW-1:0] carry;

  for (genvar i = 0; i < SW; i++) begin : g_bit
    bit_pg_t pg;
    assign pg        = bit_pg(a[i], b[i]);
    assign p_bits[i] = pg.prop;
    assign g_bits[i] = pg.gen;
    assign sum[i]    = sum_bit(pg.prop, carry[i]);
  end

  cla_carry_net #(.N(SW)) u_net (
    .p        (p_bits),
    .g        (g_bits),
    .cin      (cin),
    .c_in_pos (carry),
    .grp_p    (grp_p),
    .grp_g    (grp_g)
  );

endmodule

// File: rtl/cla_lcu.sv
// Second-level unit: slice carries and the final carry-out.
module cla_lcu #(
  parameter int unsigned NS = 4
) (
  input  logic [NS-1:0] gp,
  input  logic [NS-1:0] gg,
  input  logic          cin,
  output logic [NS-1:0] slice_cin,
  output logic          cout
);

  logic all_p;
  logic all_g;

  cla_carry_net #(.N(NS)) u_net (
    .p        (gp),
    .g        (gg),
    .cin      (cin),
    .c_in_pos (slice_cin),
    .grp_p    (all_p),
    .grp_g    (all_g)
  );

  assign cout = all_g | (all_p & cin);

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int unsigned W  = DEF_WIDTH,
  parameter int unsigned SW = DEF_SLICE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int unsigned NS = W / SW;

  logic [NS-1:0] slice_gp;
  logic [NS-1:0] slice_gg;
  logic [NS-1:0] slice_cin;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    cla_slice #(.SW(SW)) u_slice (
      .a     (a_i[s*SW +: SW]),
      .b     (b_i[s*SW +: SW]),
      .cin   (slice_cin[s]),
      .sum   (sum_o[s*SW +: SW]),
      .grp_p (slice_gp[s]),
      .grp_g (slice_gg[s])
    );
  end

  cla_lcu #(.NS(NS)) u_lcu (
    .gp        (slice_gp),
    .gg        (slice_gg),
    .cin       (cin_i),
    .slice_cin (slice_cin),
    .cout      (cout_o)
  );

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 4
) (
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic            cin_i,
  input logic [W-1:0]    sum_o,
  input logic            cout_o,
  input logic [W/SW-1:0] slice_gp,
  input logic [W/SW-1:0] slice_gg,
  input logic [W/SW-1:0] slice_cin
);

  localparam int unsigned NS = W / SW;

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      assert_sum_R1: assert (sum_o == ref_sum[W-1:0]);
      assert_cout_R2: assert (cout_o == ref_sum[W]);
    end
  end

  always_comb begin
    logic [W:0]    mask;
    logic [W:0]    low;
    logic [SW-1:0] fa;
    logic [SW-1:0] fb;
    logic [SW:0]   fs;
    if (!$isunknown({a_i, b_i, cin_i})) begin
      for (int k = 0; k < NS; k++) begin
        mask = ({{W{1'b0}}, 1'b1} << (k * SW)) - 1'b1;
        low  = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask) + {{W{1'b0}}, cin_i};
        assert_slice_carry_R3: assert (slice_cin[k] == low[k*SW]);
        fa = SW'(a_i >> (k * SW));
        fb = SW'(b_i >> (k * SW));
        fs = {1'b0, fa} + {1'b0, fb};
        if (slice_gg[k]) assert_group_gen_R4: assert (fs[SW]);
        if (slice_gp[k]) assert_group_prop_R5: assert ((fa ^ fb) == {SW{1'b1}});
        assert_pg_excl_R5: assert (!(slice_gp[k] && slice_gg[k]));
      end
    end
  end

endmodule

bind cla16_adder cla16_adder_chk #(.W(W), .SW(SW)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .slice_gp  (slice_gp),
  .slice_gg  (slice_gg),
  .slice_cin (slice_cin)
);

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         cin_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         cout_o;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla16_adder u_dut (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  // Drive just after a rising edge, compare at the next falling edge (R9).
  task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic c, input string req);
    logic [W:0] exp;
    @(posedge clk);
    a_i = a; b_i = b; cin_i = c;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    n_run++;
    if (sum_o !== exp[W-1:0] || cout_o !== exp[W]) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h c=%0d actual sum=%h cout=%0d expected sum=%h cout=%0d",
               req, a, b, c, sum_o, cout_o, exp[W-1:0], exp[W]);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    n_run++;
    if (sum_o !== '0 || cout_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 reset: actual sum=%h cout=%0d expected sum=0000 cout=0", sum_o, cout_o);
    end
  endtask

  task automatic t_zero();
    apply_check(16'h0000, 16'h0000, 1'b0, "R6");
  endtask

  task automatic t_all_ones();
    apply_check(16'hFFFF, 16'h0001, 1'b0, "R7");
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    apply_check(16'hFFFF, 16'hFFFF, 1'b0, "R2");
  endtask

  task automatic t_alternating();
    apply_check(16'h5555, 16'hAAAA, 1'b0, "R8");
    apply_check(16'h5555, 16'hAAAA, 1'b1, "R8");
    apply_check(16'hAAAA, 16'hAAAA, 1'b1, "R8");
    apply_check(16'h5555, 16'h5555, 1'b0, "R8");
  endtask

  task automatic t_slice_boundaries();
    apply_check(16'h000F, 16'h0001, 1'b0, "R3");
    apply_check(16'h00FF, 16'h0000, 1'b1, "R3");
    apply_check(16'h0FFF, 16'h0001, 1'b0, "R3");
    apply_check(16'h0F0F, 16'h00F1, 1'b0, "R3");
  endtask

  task automatic t_group_generate();
    apply_check(16'h00F0, 16'h0010, 1'b0, "R4");
    apply_check(16'h8800, 16'h8800, 1'b1, "R4");
    apply_check(16'h0009, 16'h0009, 1'b0, "R4");
  endtask

  task automatic t_group_propagate();
    apply_check(16'hFFFF, 16'h0000, 1'b1, "R5");
    apply_check(16'h3C3C, 16'hC3C3, 1'b1, "R5");
    apply_check(16'h3C3C, 16'hC3C3, 1'b0, "R5");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic         rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      apply_check(ra, rb, rc, "R1");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_zero();
    t_all_ones();
    t_alternating();
    t_slice_boundaries();
    t_group_generate();
    t_group_propagate();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule